// File: doc/BRIEF.md
# PCI Host Request Router

This block sits on the host side of a PCI hierarchy and decides where each configuration or I/O request goes. It holds a table of attached functions and a list of bridge ports. Each function is identified by an 8-bit key that packs a device number and a function number. Each function also has an owner: the host's own bus, or one of the registered bridges. Each bridge has a secondary and a subordinate bus number. Software-side setup code registers bridges and functions one at a time through a registration port. The block answers every registration with a status one cycle later.

A configuration request carries a bus number and a key. A request on the host bus is resolved against the host's own functions. Any other bus is steered through the bridge list. A bridge whose secondary bus equals the requested bus answers from the functions it owns. A bridge whose range covers the requested bus lower down gets the request forwarded. When nothing matches, the block reports a no-match error.

An I/O read or write is offered to the I/O-capable functions in registration order. Each such function claims a window of the 16-bit I/O space. The first function that claims the request completes it. Each function holds a 32-bit I/O data word, which claimed accesses read and write by byte lane. Unclaimed accesses raise the error indication. Every request gets its response exactly one cycle after it is accepted.

Top module: `pci_req_router`

## Requirements
- R1: A key holds the function number in bits [2:0] and the device number in bits [7:3]. A registration is answered on `reg_done` in the cycle after `reg_valid`, with `reg_status` 0 = accepted, 1 = duplicate, 2 = full, 3 = invalid. A function whose owner and key are both already present is rejected as duplicate, and the table is left unchanged.
- R2: A function registration when NF functions are present returns full. A bridge registration when NB bridges are present also returns full. A rejected registration changes neither count. Precedence is invalid over duplicate over full.
- R3: When a function 1..7 exists for a given owner and device number, a configuration hit on function 0 of that owner and device reports `rsp_mf`=1, whichever of the two was registered first. Otherwise `rsp_mf`=0.
- R4: A configuration request (`req_op`=0) on bus HOST_BUS (0) hits the host-owned function with the requested key and returns its table slot in `rsp_tgt`. When there is no such function it returns `rsp_err`=1.
- R5: A configuration request on another bus goes to the first bridge, in registration order, whose secondary bus equals the bus. That bridge then resolves it against the functions it owns (owner = bridge index + 1). A miss there is an error, and later bridges are not consulted.
- R6: A bridge whose secondary bus is below the requested bus, and whose subordinate bus is at or above it, gets the request forwarded: `rsp_fwd`=1 and `rsp_tgt` = bridge index.
- R7: The bridges are examined in registration order. Bridges that satisfy neither rule are skipped, and the first bridge that satisfies either rule decides the result. If no bridge matches, `rsp_err`=1.
- R8: An I/O read (`req_op`=1) or write (`req_op`=2) is claimed by the earliest-registered I/O-capable function whose window satisfies base <= addr and addr+bytes-1 <= limit. The response gives `rsp_hit`=1 and the slot in `rsp_tgt`.
- R9: An unclaimed I/O read returns `rsp_rdata`=0 with `rsp_err`=1. An unclaimed write changes no stored data and also returns `rsp_err`=1.
- R10: `req_size` 0, 1 and 2 mean 1, 2 and 4 bytes, and size 3 is never claimed. A claimed access uses byte lanes starting at addr[1:0]. Reads return those lanes right-justified, and zero beyond byte 3 of the word. Writes update only those lanes.
- R11: `req_ready` is high after reset. Every accepted request gets `rsp_valid` exactly one cycle later, with exactly one of `rsp_hit`, `rsp_fwd` and `rsp_err` set. `req_op`=3 is answered with an error.
- R12: A bridge registration with secondary bus equal to HOST_BUS, or with subordinate below secondary, is invalid. So is a function registration whose owner is greater than the number of registered bridges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Registration strobe |
| reg_bridge | input | 1 | 1 = register a bridge, 0 = register a function |
| reg_owner | input | OW | Function owner: 0 host bus, k = bridge k-1 |
| reg_key | input | 8 | Function key {device, function} |
| reg_io_en | input | 1 | Function takes part in I/O claiming |
| reg_io_base | input | 16 | Lowest I/O address claimed |
| reg_io_limit | input | 16 | Highest I/O address claimed |
| reg_sec | input | 8 | Bridge secondary bus |
| reg_sub | input | 8 | Bridge subordinate bus |
| reg_done | output | 1 | Registration status valid |
| reg_status | output | 2 | Registration status code |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_op | input | 2 | 0 config, 1 I/O read, 2 I/O write |
| req_bus | input | 8 | Configuration bus number |
| req_key | input | 8 | Configuration key |
| req_addr | input | 16 | I/O address |
| req_size | input | 2 | I/O size code |
| req_wdata | input | 32 | I/O write data, right-justified |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Function selected |
| rsp_fwd | output | 1 | Forwarded to bridge |
| rsp_err | output | 1 | No match or unclaimed |
| rsp_tgt | output | TW | Function slot or bridge index |
| rsp_mf | output | 1 | Multi-function indication of hit function |
| rsp_rdata | output | 32 | I/O read data |

## Verification
The assertions check on every cycle the fixed one-cycle timing of requests and registrations. They also check that exactly one response outcome is flagged, that errored responses carry zero data, that forwarding only answers configuration requests, and that the counts stay within capacity and never move on a rejected registration. Only the bench scenarios can show the routing decisions. These include bridge order with overlapping bus ranges, the stop at an exact-bus miss, the multi-function indication under both registration orders, and first-claim arbitration between overlapping I/O windows. The bench also covers byte-lane data, the rejection of duplicates that would have altered an existing window, and full and invalid registrations.

// File: rtl/pci_rt_pkg.sv
// Shared types for the PCI host request router.
// Assumes the size codes and op codes listed here are the only ones driven.
package pci_rt_pkg;

    typedef enum logic [1:0] {
        RS_OK   = 2'd0,
        RS_DUP  = 2'd1,
        RS_FULL = 2'd2,
        RS_BAD  = 2'd3
    } reg_status_e;

    typedef enum logic [1:0] {
        OP_CFG  = 2'd0,
        OP_IORD = 2'd1,
        OP_IOWR = 2'd2,
        OP_RSVD = 2'd3
    } req_op_e;

    // Byte count of an I/O size code; 0 marks the unsupported code.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pci_fn_table.sv
// Function table: append-only store of registered functions, each with an
// owner (host bus or bridge), an 8-bit {device,function} key, an I/O window
// and a 32-bit I/O data word. Keeps the multi-function flag of function 0
// of each owner/device up to date. Assumes add_en is only raised when the
// table has room and the entry is not a duplicate.
module pci_fn_table #(
    parameter int NF = 16,
    parameter int OW = 3,
    localparam int IW = $clog2(NF),
    localparam int CW = $clog2(NF + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [OW-1:0] add_owner,
    input  logic [7:0]    add_key,
    input  logic          add_io,
    input  logic [15:0]   add_base,
    input  logic [15:0]   add_limit,
    input  logic          dwr_en,
    input  logic [IW-1:0] dwr_idx,
    input  logic [3:0]    dwr_be,
    input  logic [31:0]   dwr_data,
    input  logic [OW-1:0] lk_owner,
    input  logic [7:0]    lk_key,
    output logic          lk_hit,
    output logic [IW-1:0] lk_idx,
    output logic          lk_mf,
    output logic          chk_dup,
    output logic [CW-1:0] count,
    output logic [NF-1:0] ent_io,
    output logic [15:0]   ent_base  [NF],
    output logic [15:0]   ent_limit [NF],
    output logic [31:0]   ent_data  [NF]
);

    logic [OW-1:0] ent_owner [NF];
    logic [7:0]    ent_key   [NF];
    logic [NF-1:0] ent_mf;
    logic [NF-1:0] vld;
    logic          sib_any;
    logic [IW-1:0] add_idx;

    assign add_idx = IW'(count);

    // Occupied slots, plus a scan for siblings 1..7 of an incoming function 0.
    always_comb begin
        sib_any = 1'b0;
        for (int i = 0; i < NF; i++) begin
            vld[i] = CW'(i) < count;
            if (vld[i] && ent_owner[i] == add_owner &&
                ent_key[i][7:3] == add_key[7:3] && ent_key[i][2:0] != 3'd0)
                sib_any = 1'b1;
        end
    end

    // Lookup of the requested owner/key and duplicate check of the incoming one.
    always_comb begin
        lk_hit  = 1'b0;
        lk_idx  = '0;
        chk_dup = 1'b0;
        for (int i = 0; i < NF; i++) begin
            if (!lk_hit && vld[i] && ent_owner[i] == lk_owner && ent_key[i] == lk_key) begin
                lk_hit = 1'b1;
                lk_idx = IW'(i);
            end
            if (vld[i] && ent_owner[i] == add_owner && ent_key[i] == add_key)
                chk_dup = 1'b1;
        end
        lk_mf = lk_hit && ent_mf[lk_idx];
    end

    // Entry storage, multi-function upkeep and byte-lane data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            ent_io <= '0;
            ent_mf <= '0;
            for (int i = 0; i < NF; i++) begin
                ent_owner[i] <= '0;
                ent_key[i]   <= '0;
                ent_base[i]  <= '0;
                ent_limit[i] <= '0;
                ent_data[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (add_en && vld[i] && ent_owner[i] == add_owner &&
                    ent_key[i][7:3] == add_key[7:3] && ent_key[i][2:0] == 3'd0 &&
                    add_key[2:0] != 3'd0)
                    ent_mf[i] <= 1'b1;
            end
            if (dwr_en) begin
                for (int b = 0; b < 4; b++)
                    if (dwr_be[b])
                        ent_data[dwr_idx][8*b +: 8] <= dwr_data[8*b +: 8];
            end
            if (add_en) begin
                ent_owner[add_idx] <= add_owner;
                ent_key[add_idx]   <= add_key;
                ent_io[add_idx]    <= add_io;
                ent_base[add_idx]  <= add_base;
                ent_limit[add_idx] <= add_limit;
                ent_mf[add_idx]    <= (add_key[2:0] == 3'd0) && sib_any;
                count              <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pci_bridge_list.sv
// Bridge list: append-only store of secondary/subordinate bus pairs and the
// configuration routing decision. The first bridge in registration order
// that matches exactly or by range wins. Assumes NB >= 2.
module pci_bridge_list #(
    parameter int NB = 4,
    localparam int BIW = $clog2(NB),
    localparam int CW  = $clog2(NB + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           add_en,
    input  logic [7:0]     add_sec,
    input  logic [7:0]     add_sub,
    input  logic [7:0]     rt_bus,
    output logic           rt_any,
    output logic           rt_exact,
    output logic [BIW-1:0] rt_idx,
    output logic [CW-1:0]  count
);

    logic [7:0] sec [NB];
    logic [7:0] sub [NB];

    // Priority scan over the bridges for the requested bus.
    always_comb begin
        rt_any   = 1'b0;
        rt_exact = 1'b0;
        rt_idx   = '0;
        for (int i = 0; i < NB; i++) begin
            if (!rt_any && CW'(i) < count) begin
                if (sec[i] == rt_bus) begin
                    rt_any   = 1'b1;
                    rt_exact = 1'b1;
                    rt_idx   = BIW'(i);
                end else if (sec[i] < rt_bus && sub[i] >= rt_bus) begin
                    rt_any = 1'b1;
                    rt_idx = BIW'(i);
                end
            end
        end
    end

    // Appends a bridge at the next free position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < NB; i++) begin
                sec[i] <= '0;
                sub[i] <= '0;
            end
        end else if (add_en) begin
            sec[BIW'(count)] <= add_sec;
            sub[BIW'(count)] <= add_sub;
            count            <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pci_io_claim.sv
// I/O claim arbiter: finds the earliest-registered I/O-capable function
// whose window covers every byte of the access. Pure combinational.
// Assumes disabled or unused slots have their ent_io bit clear.
module pci_io_claim #(
    parameter int NF = 16,
    localparam int IW = $clog2(NF)
) (
    input  logic [NF-1:0] ent_io,
    input  logic [15:0]   ent_base  [NF],
    input  logic [15:0]   ent_limit [NF],
    input  logic [15:0]   addr,
    input  logic [2:0]    nbytes,
    output logic          claim,
    output logic [IW-1:0] idx
);

    logic [16:0] last;

    // Window test in slot order; the first covering slot claims.
    always_comb begin
        last  = {1'b0, addr} + 17'(nbytes) - 17'd1;
        claim = 1'b0;
        idx   = '0;
        for (int i = 0; i < NF; i++) begin
            if (!claim && nbytes != 3'd0 && ent_io[i] &&
                addr >= ent_base[i] && last <= {1'b0, ent_limit[i]}) begin
                claim = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/pci_req_router.sv
// PCI host request router top. Validates registrations of bridges and
// functions. Routes configuration requests to a local function, a bridge's
// function, a forwarding bridge or no-match. Arbitrates I/O by first claim.
// Every request is answered one cycle after acceptance; req_ready is high
// whenever the block is out of reset.
module pci_req_router #(
    parameter int         NF       = 16,
    parameter int         NB       = 4,
    parameter logic [7:0] HOST_BUS = 8'd0,
    localparam int OW  = $clog2(NB + 1),
    localparam int FIW = $clog2(NF),
    localparam int BIW = $clog2(NB),
    localparam int TW  = (FIW > BIW) ? FIW : BIW,
    localparam int FCW = $clog2(NF + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_valid,
    input  logic          reg_bridge,
    input  logic [OW-1:0] reg_owner,
    input  logic [7:0]    reg_key,
    input  logic          reg_io_en,
    input  logic [15:0]   reg_io_base,
    input  logic [15:0]   reg_io_limit,
    input  logic [7:0]    reg_sec,
    input  logic [7:0]    reg_sub,
    output logic          reg_done,
    output logic [1:0]    reg_status,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [7:0]    req_bus,
    input  logic [7:0]    req_key,
    input  logic [15:0]   req_addr,
    input  logic [1:0]    req_size,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic          rsp_fwd,
    output logic          rsp_err,
    output logic [TW-1:0] rsp_tgt,
    output logic          rsp_mf,
    output logic [31:0]   rsp_rdata
);
    import pci_rt_pkg::*;

    logic [FCW-1:0] fn_count;
    logic [OW-1:0]  br_count;
    logic [NF-1:0]  ent_io;
    logic [15:0]    ent_base  [NF];
    logic [15:0]    ent_limit [NF];
    logic [31:0]    ent_data  [NF];
    logic           lk_hit, lk_mf, fn_dup;
    logic [FIW-1:0] lk_idx;
    logic [OW-1:0]  lk_owner;
    logic           rt_any, rt_exact;
    logic [BIW-1:0] rt_idx;
    logic           cl_claim;
    logic [FIW-1:0] cl_idx;
    logic [2:0]     nbytes;
    logic [1:0]     off;
    logic [3:0]     wr_be;
    logic [31:0]    wr_word, rd_word;
    logic           dwr_en;
    reg_status_e    status_d;
    logic           fn_add, br_add;
    logic           hit_d, fwd_d, err_d, mf_d;
    logic [TW-1:0]  tgt_d;
    logic [31:0]    rdata_d;

    // Registration decision: invalid over duplicate over full.
    always_comb begin
        if (reg_bridge) begin
            if (reg_sec == HOST_BUS || reg_sub < reg_sec)    status_d = RS_BAD;
            else if (br_count == OW'(NB))                    status_d = RS_FULL;
            else                                             status_d = RS_OK;
        end else begin
            if (reg_owner > br_count)                        status_d = RS_BAD;
            else if (fn_dup)                                 status_d = RS_DUP;
            else if (fn_count == FCW'(NF))                   status_d = RS_FULL;
            else                                             status_d = RS_OK;
        end
        fn_add = reg_valid && !reg_bridge && status_d == RS_OK;
        br_add = reg_valid &&  reg_bridge && status_d == RS_OK;
    end

    // Owner used for the configuration lookup: host or the exact bridge.
    assign lk_owner = (req_bus == HOST_BUS) ? '0 : OW'(rt_idx) + 1'b1;

    // I/O byte-lane shaping for the claimed function's data word.
    always_comb begin
        nbytes  = size_bytes(req_size);
        off     = req_addr[1:0];
        rd_word = ent_data[cl_idx] >> (8 * off);
        wr_word = req_wdata << (8 * off);
        for (int b = 0; b < 4; b++) begin
            wr_be[b] = (3'(b) >= 3'(off)) && (3'(b) < 3'(off) + nbytes);
            if (3'(b) >= nbytes) rd_word[8*b +: 8] = 8'h00;
        end
        dwr_en = req_valid && req_op == OP_IOWR && cl_claim;
    end

    // Response outcome for the request presented this cycle.
    always_comb begin
        hit_d   = 1'b0;
        fwd_d   = 1'b0;
        err_d   = 1'b0;
        mf_d    = 1'b0;
        tgt_d   = '0;
        rdata_d = '0;
        case (req_op)
            OP_CFG: begin
                if (req_bus == HOST_BUS || (rt_any && rt_exact)) begin
                    hit_d = lk_hit;
                    err_d = !lk_hit;
                    mf_d  = lk_mf;
                    tgt_d = lk_hit ? TW'(lk_idx) : '0;
                end else if (rt_any) begin
                    fwd_d = 1'b1;
                    tgt_d = TW'(rt_idx);
                end else begin
                    err_d = 1'b1;
                end
            end
            OP_IORD, OP_IOWR: begin
                hit_d   = cl_claim;
                err_d   = !cl_claim;
                tgt_d   = cl_claim ? TW'(cl_idx) : '0;
                rdata_d = (cl_claim && req_op == OP_IORD) ? rd_word : 32'h0;
            end
            default: err_d = 1'b1;
        endcase
    end

    // Response and registration status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_ready  <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fwd    <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_mf     <= 1'b0;
            rsp_tgt    <= '0;
            rsp_rdata  <= '0;
            reg_done   <= 1'b0;
            reg_status <= '0;
        end else begin
            req_ready  <= 1'b1;
            rsp_valid  <= req_valid;
            rsp_hit    <= req_valid && hit_d;
            rsp_fwd    <= req_valid && fwd_d;
            rsp_err    <= req_valid && err_d;
            rsp_mf     <= req_valid && mf_d;
            rsp_tgt    <= req_valid ? tgt_d : '0;
            rsp_rdata  <= req_valid ? rdata_d : '0;
            reg_done   <= reg_valid;
            reg_status <= reg_valid ? status_d : '0;
        end
    end

    pci_fn_table #(.NF(NF), .OW(OW)) u_fn (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_en    (fn_add),
        .add_owner (reg_owner),
        .add_key   (reg_key),
        .add_io    (reg_io_en),
        .add_base  (reg_io_base),
        .add_limit (reg_io_limit),
        .dwr_en    (dwr_en),
        .dwr_idx   (cl_idx),
        .dwr_be    (wr_be),
        .dwr_data  (wr_word),
        .lk_owner  (lk_owner),
        .lk_key    (req_key),
        .lk_hit    (lk_hit),
        .lk_idx    (lk_idx),
        .lk_mf     (lk_mf),
        .chk_dup   (fn_dup),
        .count     (fn_count),
        .ent_io    (ent_io),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .ent_data  (ent_data)
    );

    pci_bridge_list #(.NB(NB)) u_br (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (br_add),
        .add_sec  (reg_sec),
        .add_sub  (reg_sub),
        .rt_bus   (req_bus),
        .rt_any   (rt_any),
        .rt_exact (rt_exact),
        .rt_idx   (rt_idx),
        .count    (br_count)
    );

    pci_io_claim #(.NF(NF)) u_io (
        .ent_io    (ent_io),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .addr      (req_addr),
        .nbytes    (nbytes),
        .claim     (cl_claim),
        .idx       (cl_idx)
    );

endmodule

// File: rtl/pci_req_router_chk.sv
// Property checker for pci_req_router, attached with bind. Observes ports
// and the two table counts; drives nothing.
module pci_req_router_chk #(
    parameter int NF = 16,
    parameter int NB = 4,
    localparam int OW  = $clog2(NB + 1),
    localparam int FIW = $clog2(NF),
    localparam int BIW = $clog2(NB),
    localparam int TW  = (FIW > BIW) ? FIW : BIW,
    localparam int FCW = $clog2(NF + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [1:0]     req_op,
    input logic           reg_valid,
    input logic           reg_done,
    input logic [1:0]     reg_status,
    input logic           rsp_valid,
    input logic           rsp_hit,
    input logic           rsp_fwd,
    input logic           rsp_err,
    input logic [TW-1:0]  rsp_tgt,
    input logic [31:0]    rsp_rdata,
    input logic [FCW-1:0] fn_count,
    input logic [OW-1:0]  br_count
);

    // R11: response exactly one cycle after every accepted request.
    assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R11: exactly one outcome per response.
    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_fwd, rsp_err}) == 1);
    // R9: errored responses carry zero data.
    assert_unclaimed_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == 32'h0);
    // R6: forwarding answers configuration requests only, naming a real bridge.
    assert_fwd_cfg_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fwd |-> $past(req_op) == 2'd0 && rsp_tgt < TW'(NB));
    // R1: registration status one cycle after the strobe.
    assert_reg_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid |=> reg_done);
    assert_no_spurious_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_valid |=> !reg_done);
    // R2: counts stay within capacity.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fn_count <= FCW'(NF) && br_count <= OW'(NB));
    // R2: a rejected registration leaves both counts unchanged.
    assert_reject_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done && reg_status != 2'd0 |->
            fn_count == $past(fn_count) && br_count == $past(br_count));
    // R2: full is only reported when one of the tables was full.
    assert_full_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done && reg_status == 2'd2 |->
            $past(fn_count) == FCW'(NF) || $past(br_count) == OW'(NB));

endmodule

bind pci_req_router pci_req_router_chk #(.NF(NF), .NB(NB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .reg_valid  (reg_valid),
    .reg_done   (reg_done),
    .reg_status (reg_status),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fwd    (rsp_fwd),
    .rsp_err    (rsp_err),
    .rsp_tgt    (rsp_tgt),
    .rsp_rdata  (rsp_rdata),
    .fn_count   (fn_count),
    .br_count   (br_count)
);

// File: tb/test_pci_req_router.sv
// Bench for pci_req_router at default size (16 functions, 4 bridges).
// Builds a hierarchy, then sweeps configuration buses x keys and I/O
// addresses x sizes, comparing against an arithmetic model kept here.
module test_pci_req_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_bridge = 1'b0, reg_io_en = 1'b0;
    logic [2:0]  reg_owner = '0;
    logic [7:0]  reg_key = '0, reg_sec = '0, reg_sub = '0;
    logic [15:0] reg_io_base = '0, reg_io_limit = '0;
    logic        reg_done;
    logic [1:0]  reg_status;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0, req_size = '0;
    logic [7:0]  req_bus = '0, req_key = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_hit, rsp_fwd, rsp_err, rsp_mf;
    logic [3:0]  rsp_tgt;
    logic [31:0] rsp_rdata;

    int nvec = 0;
    int nmis = 0;

    // Model of the registered hierarchy.
    int          m_fn_n = 0;
    int          m_br_n = 0;
    int          m_owner [16];
    int          m_key   [16];
    bit          m_io    [16];
    int          m_base  [16];
    int          m_lim   [16];
    logic [31:0] m_data  [16];
    int          m_sec   [4];
    int          m_sub   [4];

    // 50 MHz clock: 20-unit period.
    always #10 clk = ~clk;

    pci_req_router i_pci_req_router (.*);

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int find_fn(input int owner, input int key);
        for (int i = 0; i < m_fn_n; i++)
            if (m_owner[i] == owner && m_key[i] == key) return i;
        return -1;
    endfunction

    function automatic bit calc_mf(input int i);
        if ((m_key[i] & 7) != 0) return 1'b0;
        for (int j = 0; j < m_fn_n; j++)
            if (m_owner[j] == m_owner[i] && (m_key[j] >> 3) == (m_key[i] >> 3) &&
                (m_key[j] & 7) != 0) return 1'b1;
        return 1'b0;
    endfunction

    // Registration of a bridge (br=1) or function; checks status (R1, R2, R12).
    task automatic do_reg(input string tag, input bit br, input int owner, input int key,
                          input bit io, input int base, input int lim,
                          input int sec, input int sub);
        int exp;
        if (br) begin
            if (sec == 0 || sub < sec) exp = 3;
            else if (m_br_n == 4)      exp = 2;
            else                       exp = 0;
        end else begin
            if (owner > m_br_n)              exp = 3;
            else if (find_fn(owner, key) >= 0) exp = 1;
            else if (m_fn_n == 16)           exp = 2;
            else                             exp = 0;
        end
        reg_valid    = 1'b1;
        reg_bridge   = br;
        reg_owner    = 3'(owner);
        reg_key      = 8'(key);
        reg_io_en    = io;
        reg_io_base  = 16'(base);
        reg_io_limit = 16'(lim);
        reg_sec      = 8'(sec);
        reg_sub      = 8'(sub);
        @(negedge clk);
        check(tag, "reg status", {62'(reg_done), reg_status}, {62'd1, 2'(exp)});
        reg_valid = 1'b0;
        if (exp == 0) begin
            if (br) begin
                m_sec[m_br_n] = sec; m_sub[m_br_n] = sub; m_br_n++;
            end else begin
                m_owner[m_fn_n] = owner; m_key[m_fn_n] = key; m_io[m_fn_n] = io;
                m_base[m_fn_n] = base; m_lim[m_fn_n] = lim; m_data[m_fn_n] = '0;
                m_fn_n++;
            end
        end
    endtask

    // Configuration request against the routing rules (R3-R7).
    task automatic do_cfg(input int bus, input int key);
        bit hit = 0, fwd = 0, err = 0, mf = 0, done = 0;
        int tgt = 0, idx;
        string tag = "R7";
        if (bus == 0) begin
            tag = "R4";
            idx = find_fn(0, key);
            if (idx >= 0) begin hit = 1; tgt = idx; mf = calc_mf(idx); end else err = 1;
        end else begin
            for (int b = 0; b < m_br_n; b++) begin
                if (!done && m_sec[b] == bus) begin
                    done = 1; tag = "R5";
                    idx = find_fn(b + 1, key);
                    if (idx >= 0) begin hit = 1; tgt = idx; mf = calc_mf(idx); end else err = 1;
                end else if (!done && m_sec[b] < bus && m_sub[b] >= bus) begin
                    done = 1; tag = "R6"; fwd = 1; tgt = b;
                end
            end
            if (!done) err = 1;
        end
        if (mf) tag = "R3";
        req_valid = 1'b1; req_op = 2'd0; req_bus = 8'(bus); req_key = 8'(key);
        @(negedge clk);
        check(tag, "cfg rsp", {57'(rsp_valid), rsp_hit, rsp_fwd, rsp_err, rsp_mf, rsp_tgt},
              {57'd1, hit, fwd, err, mf, 4'(tgt)});
        req_valid = 1'b0;
    endtask

    // I/O request against first-claim, lanes and unclaimed rules (R8-R10).
    task automatic do_io(input bit wr, input int addr, input int size, input logic [31:0] wd);
        int nb, idx = -1, off;
        logic [31:0] exp_rd = '0;
        string tag;
        nb  = (size == 0) ? 1 : (size == 1) ? 2 : (size == 2) ? 4 : 0;
        off = addr & 3;
        for (int i = 0; i < m_fn_n; i++)
            if (idx < 0 && nb != 0 && m_io[i] && addr >= m_base[i] &&
                addr + nb - 1 <= m_lim[i]) idx = i;
        tag = (idx < 0) ? "R9" : (size == 3 || off != 0) ? "R10" : "R8";
        if (idx >= 0) begin
            for (int j = 0; j < nb; j++)
                if (off + j < 4) begin
                    if (wr) m_data[idx][8*(off+j) +: 8] = wd[8*j +: 8];
                    else    exp_rd[8*j +: 8] = m_data[idx][8*(off+j) +: 8];
                end
        end
        req_valid = 1'b1; req_op = wr ? 2'd2 : 2'd1; req_addr = 16'(addr);
        req_size = 2'(size); req_wdata = wd;
        @(negedge clk);
        check(tag, wr ? "io wr rsp" : "io rd rsp",
              {56'(rsp_valid), rsp_hit, rsp_err, rsp_fwd, rsp_tgt},
              {56'd1, idx >= 0, idx < 0, 1'b0, 4'(idx < 0 ? 0 : idx)});
        check(tag, "io rdata", 64'(rsp_rdata), 64'(exp_rd));
        req_valid = 1'b0;
    endtask

    // Watchdog: an expired run counts as a miscompare.
    initial begin
        #3000000;
        nmis++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "reset state", {61'(req_ready), rsp_valid, reg_done},
              {61'd1, 1'b0, 1'b0});

        // Bridges, including invalid and overflow attempts (R12, R2).
        do_reg("R1",  1, 0, 0, 0, 0, 0, 1, 3);
        do_reg("R1",  1, 0, 0, 0, 0, 0, 4, 4);
        do_reg("R7",  1, 0, 0, 0, 0, 0, 2, 5);
        do_reg("R12", 1, 0, 0, 0, 0, 0, 0, 2);
        do_reg("R12", 1, 0, 0, 0, 0, 0, 5, 3);
        do_reg("R1",  1, 0, 0, 0, 0, 0, 6, 7);
        do_reg("R2",  1, 0, 0, 0, 0, 0, 8, 9);

        // Functions: nonzero function before its function 0, overlapping windows.
        do_reg("R3",  0, 0, 8'h13, 1, 16'h0010, 16'h001F, 0, 0);
        do_reg("R3",  0, 0, 8'h10, 0, 0, 0, 0, 0);
        do_reg("R8",  0, 0, 8'h28, 1, 16'h0018, 16'h0027, 0, 0);
        do_reg("R5",  0, 1, 8'h08, 0, 0, 0, 0, 0);
        do_reg("R5",  0, 2, 8'h01, 1, 16'h0040, 16'h0043, 0, 0);
        do_reg("R1",  0, 0, 8'h13, 1, 16'h0050, 16'h005F, 0, 0);
        do_reg("R12", 0, 5, 8'h00, 0, 0, 0, 0, 0);
        do_reg("R3",  0, 3, 8'h38, 0, 0, 0, 0, 0);
        do_reg("R3",  0, 3, 8'h3A, 0, 0, 0, 0, 0);
        for (int k = 0; k < 9; k++)
            do_reg("R2", 0, 4, 8'h48 + k, 0, 0, 0, 0, 0);
        do_reg("R2",  0, 0, 8'h77, 0, 0, 0, 0, 0);
        do_reg("R2",  0, 4, 8'h48, 0, 0, 0, 0, 0);

        // Idle cycle: no response without a request (R11).
        @(negedge clk);
        check("R11", "idle rsp_valid", 64'(rsp_valid), 64'd0);

        // Configuration sweep over buses 0..8 and every key.
        for (int bus = 0; bus < 9; bus++)
            for (int key = 0; key < 256; key++)
                do_cfg(bus, key);

        // Reserved op gets an error (R11).
        req_valid = 1'b1; req_op = 2'd3;
        @(negedge clk);
        check("R11", "rsvd op", {60'(rsp_valid), rsp_hit, rsp_fwd, rsp_err},
              {60'd1, 1'b0, 1'b0, 1'b1});
        req_valid = 1'b0;

        // I/O sweep: read, write, read back at every address and size.
        for (int a = 0; a < 16'h0068; a++)
            for (int s = 0; s < 4; s++) begin
                do_io(1'b0, a, s, 32'h0);
                do_io(1'b1, a, s, {8'(a), 8'(s), 8'(a ^ 8'h5A), 8'(a + s + 1)});
                do_io(1'b0, a, s, 32'h0);
            end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule